// File: doc/BRIEF.md
# Capability permission masking unit

This execution unit carries out the "restrict permissions" operation on a 257-bit tagged capability. A 32-bit instruction word arrives with a valid strobe. The unit decodes the word and points the register files at the source capability and the mask register through two index outputs. From the values that come back, it either produces a narrowed copy of the capability for the destination register or raises an exception with a cause code and the index of the faulting register.

The narrowed copy keeps the tag, object type, sealed flag and the three 64-bit address fields (cursor, base, length). Every permission bit is ANDed with a chosen bit of the mask register, and the padding bits are forced to zero. Checks run in a fixed priority order, so a single instruction reports only the most important fault it has. The outcome is registered and appears one cycle after the strobe.

Top module: `capmask_unit`

## Requirements
- R1: A word is recognised only when bits 31..26 are 010010, bits 25..21 are 00100 and bits 5..0 are all zero. A strobe with any other word gives neither write-enable nor exception one cycle later.
- R2: `src_sel` equals instruction bits 15..11 and `gpr_sel` equals bits 10..6. Both follow `insn_word` combinationally.
- R3: One cycle after a strobe with a recognised word, exactly one of `wr_en` and `exc_valid` is high. Without a strobe both are low.
- R4: When `dst_locked` is set, the exception has cause 0x18 and index = destination field (bits 20..16), whatever the other flags are.
- R5: Otherwise, when `src_locked` is set, the exception has cause 0x18 and index = source field (bits 15..11).
- R6: Otherwise, a source whose tag (bit 256) is clear gives cause 0x02 with the source index.
- R7: Otherwise, a source whose sealed flag (bit 192) is set gives cause 0x03 with the source index. A source that passes every check produces a write.
- R8: On a write, `wr_idx` is the destination field. Bits 256, 247..224, 192 and 191..0 of `wr_cap` equal the source.
- R9: On a write, `wr_cap[223:208]` = source[223:208] AND mask[30:15], and `wr_cap[207:203]` = source[207:203] AND mask[14:10].
- R10: On a write, `wr_cap[200:193]` = source[200:193] AND mask[7:0].
- R11: `wr_cap[255:248]` and `wr_cap[202:201]` are always zero, whatever the source holds.
- R12: Mask bits 63..31, 9 and 8 have no effect on the result.
- R13: While `exc_valid` is low, `exc_cause` and `exc_idx` are zero. While `wr_en` is low, `wr_idx` and `wr_cap` are zero.
- R14: During reset all outputs of the register stage are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | Instruction strobe |
| insn_word | input | 32 | Instruction word |
| src_cap | input | 257 | Source capability read at `src_sel` |
| mask_gpr | input | XLEN | General register read at `gpr_sel` |
| dst_locked | input | 1 | Destination register is inaccessible |
| src_locked | input | 1 | Source register is inaccessible |
| src_sel | output | 5 | Decoded source capability index |
| gpr_sel | output | 5 | Decoded mask register index |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | 5 | Destination index |
| wr_cap | output | 257 | Narrowed capability |
| exc_valid | output | 1 | Exception strobe |
| exc_cause | output | 8 | Exception cause code |
| exc_idx | output | 5 | Faulting register index |

## Verification
The hardest case to reach is an instruction that carries several faults at once, where only the highest-priority one may be reported. Random data almost never lines up the two lock flags, a clear tag and a set sealed flag in the same cycle. The stimulus therefore walks all sixteen combinations of the four fault conditions on one fixed word. Separate pairs of operations differ only in the ignored mask bits, and others set the padding bits in the source.

// File: rtl/capmask_pkg.sv
package capmask_pkg;
   localparam int CAP_W    = 257;
   localparam int IDX_W    = 5;
   localparam int CAUSE_W  = 8;

   // capability bit positions the result logic depends on
   localparam int TAG_POS   = 256;
   localparam int PAD_HI    = 255;
   localparam int PAD_LO    = 248;
   localparam int OTYPE_HI  = 247;
   localparam int OTYPE_LO  = 224;
   localparam int SWP_LO    = 208;
   localparam int SWP_N     = 16;
   localparam int SYSA_LO   = 203;
   localparam int SYSA_N    = 5;
   localparam int RSV_HI    = 202;
   localparam int RSV_LO    = 201;
   localparam int HWP_LO    = 193;
   localparam int HWP_N     = 8;
   localparam int SEAL_POS  = 192;
   localparam int ADDR_HI   = 191;

   // mask register bit positions
   localparam int MSWP_LO   = 15;
   localparam int MSYS_LO   = 10;
   localparam int MHWP_LO   = 0;
   localparam int MASK_USED = 31;

   // opcode fields
   localparam logic [5:0] OP_MAJOR = 6'b010010;
   localparam logic [4:0] OP_MINOR = 5'b00100;

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_NONE   = 8'h00,
      CAUSE_TAG    = 8'h02,
      CAUSE_SEAL   = 8'h03,
      CAUSE_ACCESS = 8'h18
   } cause_e;

   typedef struct packed {
      logic             hit;
      logic [IDX_W-1:0] dst;
      logic [IDX_W-1:0] src;
      logic [IDX_W-1:0] msk;
   } dec_t;
endpackage

// File: rtl/capmask_decode.sv
module capmask_decode
   import capmask_pkg::*;
(
   input  logic [31:0] word,
   output dec_t        dec
);
   logic major_ok;
   logic minor_ok;
   logic tail_ok;

   assign major_ok = (word[31:26] == OP_MAJOR);
   assign minor_ok = (word[25:21] == OP_MINOR);
   assign tail_ok  = (word[5:3] == 3'b000) && (word[2:0] == 3'b000);

   assign dec.hit = major_ok & minor_ok & tail_ok;
   assign dec.dst = word[20:16];
   assign dec.src = word[15:11];
   assign dec.msk = word[10:6];
endmodule

// File: rtl/capmask_check.sv
module capmask_check
   import capmask_pkg::*;
(
   input  logic             dst_lock,
   input  logic             src_lock,
   input  logic             tag,
   input  logic             sealed,
   input  logic [IDX_W-1:0] dst,
   input  logic [IDX_W-1:0] src,
   output logic             pass,
   output cause_e           cause,
   output logic [IDX_W-1:0] bad_idx
);
   always_comb begin
      pass    = 1'b0;
      cause   = CAUSE_NONE;
      bad_idx = '0;
      if (dst_lock) begin
         cause   = CAUSE_ACCESS;
         bad_idx = dst;
      end else if (src_lock) begin
         cause   = CAUSE_ACCESS;
         bad_idx = src;
      end else if (!tag) begin
         cause   = CAUSE_TAG;
         bad_idx = src;
      end else if (sealed) begin
         cause   = CAUSE_SEAL;
         bad_idx = src;
      end else begin
         pass = 1'b1;
      end
   end
endmodule

// File: rtl/capmask_apply.sv
module capmask_apply
   import capmask_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [CAP_W-1:0] cap_in,
   input  logic [XLEN-1:0]  mask,
   output logic [CAP_W-1:0] cap_out
);
   // copied fields
   assign cap_out[TAG_POS]             = cap_in[TAG_POS];
   assign cap_out[PAD_HI:PAD_LO]       = '0;
   assign cap_out[OTYPE_HI:OTYPE_LO]   = cap_in[OTYPE_HI:OTYPE_LO];
   assign cap_out[RSV_HI:RSV_LO]       = '0;
   assign cap_out[SEAL_POS]            = cap_in[SEAL_POS];
   assign cap_out[ADDR_HI:0]           = cap_in[ADDR_HI:0];

   // masked permission groups
   for (genvar i = 0; i < SWP_N; i++) begin : g_swp
      assign cap_out[SWP_LO+i] = cap_in[SWP_LO+i] & mask[MSWP_LO+i];
   end
   for (genvar i = 0; i < SYSA_N; i++) begin : g_sys
      assign cap_out[SYSA_LO+i] = cap_in[SYSA_LO+i] & mask[MSYS_LO+i];
   end
   for (genvar i = 0; i < HWP_N; i++) begin : g_hwp
      assign cap_out[HWP_LO+i] = cap_in[HWP_LO+i] & mask[MHWP_LO+i];
   end

   logic unused_bits;
   assign unused_bits = ^{cap_in[PAD_HI:PAD_LO], cap_in[RSV_HI:RSV_LO],
                          mask[XLEN-1:MASK_USED], mask[9:8]};
endmodule

// File: rtl/capmask_unit.sv
module capmask_unit
   import capmask_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter bit CLEAR_IDLE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 insn_valid,
   input  logic [31:0]          insn_word,
   input  logic [CAP_W-1:0]     src_cap,
   input  logic [XLEN-1:0]      mask_gpr,
   input  logic                 dst_locked,
   input  logic                 src_locked,
   output logic [IDX_W-1:0]     src_sel,
   output logic [IDX_W-1:0]     gpr_sel,
   output logic                 wr_en,
   output logic [IDX_W-1:0]     wr_idx,
   output logic [CAP_W-1:0]     wr_cap,
   output logic                 exc_valid,
   output logic [CAUSE_W-1:0]   exc_cause,
   output logic [IDX_W-1:0]     exc_idx
);
   if (XLEN < MASK_USED + 1) begin : g_bad_xlen
      $error("capmask_unit: XLEN must cover mask bit 31");
   end

   dec_t             dec;
   logic             pass;
   cause_e           cause;
   logic [IDX_W-1:0] bad_idx;
   logic [CAP_W-1:0] narrowed;
   logic             fire_wr;
   logic             fire_exc;

   capmask_decode u_dec (
      .word (insn_word),
      .dec  (dec)
   );

   capmask_check u_chk (
      .dst_lock (dst_locked),
      .src_lock (src_locked),
      .tag      (src_cap[TAG_POS]),
      .sealed   (src_cap[SEAL_POS]),
      .dst      (dec.dst),
      .src      (dec.src),
      .pass     (pass),
      .cause    (cause),
      .bad_idx  (bad_idx)
   );

   capmask_apply #(.XLEN(XLEN)) u_app (
      .cap_in  (src_cap),
      .mask    (mask_gpr),
      .cap_out (narrowed)
   );

   assign src_sel  = dec.src;
   assign gpr_sel  = dec.msk;
   assign fire_wr  = insn_valid & dec.hit & pass;
   assign fire_exc = insn_valid & dec.hit & ~pass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en     <= 1'b0;
         exc_valid <= 1'b0;
         exc_cause <= '0;
         exc_idx   <= '0;
      end else begin
         wr_en     <= fire_wr;
         exc_valid <= fire_exc;
         exc_cause <= fire_exc ? cause : CAUSE_NONE;
         exc_idx   <= fire_exc ? bad_idx : '0;
      end
   end

   if (CLEAR_IDLE) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_idx <= '0;
            wr_cap <= '0;
         end else begin
            wr_idx <= fire_wr ? dec.dst : '0;
            wr_cap <= fire_wr ? narrowed : '0;
         end
      end
   end else begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_idx <= '0;
            wr_cap <= '0;
         end else if (fire_wr) begin
            wr_idx <= dec.dst;
            wr_cap <= narrowed;
         end
      end
   end
endmodule

// File: rtl/capmask_sva.sv
module capmask_sva #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            insn_valid,
   input logic [31:0]     insn_word,
   input logic [256:0]    src_cap,
   input logic            dst_locked,
   input logic            src_locked,
   input logic            wr_en,
   input logic [256:0]    wr_cap,
   input logic            exc_valid,
   input logic [7:0]      exc_cause,
   input logic [4:0]      exc_idx
);
   logic rec;
   assign rec = insn_valid && insn_word[31:21] == 11'b010010_00100 && insn_word[5:0] == 6'd0;

   assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && exc_valid));

   assert_respond_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rec |=> (wr_en || exc_valid));

   assert_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !rec |=> (!wr_en && !exc_valid));

   assert_dst_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rec && dst_locked) |=> (exc_valid && exc_cause == 8'h18 && exc_idx == $past(insn_word[20:16])));

   assert_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rec && !dst_locked && !src_locked && !src_cap[256])
      |=> (exc_cause == 8'h02 && exc_idx == $past(insn_word[15:11])));

   assert_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rec && !dst_locked && !src_locked && src_cap[256] && !src_cap[192])
      |=> (wr_en && wr_cap[256] && wr_cap[191:0] == $past(src_cap[191:0])));

   assert_pad_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cap[255:248] == 8'd0 && wr_cap[202:201] == 2'd0));

   assert_idle_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_valid |-> (exc_cause == 8'd0 && exc_idx == 5'd0));
endmodule

bind capmask_unit capmask_sva #(.XLEN(XLEN)) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_valid (insn_valid),
   .insn_word  (insn_word),
   .src_cap    (src_cap),
   .dst_locked (dst_locked),
   .src_locked (src_locked),
   .wr_en      (wr_en),
   .wr_cap     (wr_cap),
   .exc_valid  (exc_valid),
   .exc_cause  (exc_cause),
   .exc_idx    (exc_idx)
);

// File: tb/capmask_unit_tb_top.sv
`timescale 1ns/1ps
module capmask_unit_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         insn_valid = 1'b0;
   logic [31:0]  insn_word = '0;
   logic [256:0] src_cap = '0;
   logic [63:0]  mask_gpr = '0;
   logic         dst_locked = 1'b0;
   logic         src_locked = 1'b0;
   logic [4:0]   src_sel, gpr_sel, wr_idx, exc_idx;
   logic         wr_en, exc_valid;
   logic [256:0] wr_cap;
   logic [7:0]   exc_cause;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   capmask_unit dut_i (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
      .src_cap(src_cap), .mask_gpr(mask_gpr), .dst_locked(dst_locked),
      .src_locked(src_locked), .src_sel(src_sel), .gpr_sel(gpr_sel),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_cap(wr_cap), .exc_valid(exc_valid),
      .exc_cause(exc_cause), .exc_idx(exc_idx));

   task automatic check(input bit ok, input string req, input string what,
                        input logic [256:0] act, input logic [256:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [4:0] d, input logic [4:0] s, input logic [4:0] m);
      return {6'b010010, 5'b00100, d, s, m, 6'b000000};
   endfunction

   // behavioural model of the narrowed capability
   function automatic logic [256:0] model_cap(input logic [256:0] c, input logic [63:0] m);
      logic [256:0] r = '0;
      r[256]     = c[256];
      r[247:224] = c[247:224];
      r[192:0]   = c[192:0];
      for (int k = 0; k < 8; k++)  r[193+k] = c[193+k] & m[k];
      for (int k = 0; k < 5; k++)  r[203+k] = c[203+k] & m[10+k];
      for (int k = 0; k < 16; k++) r[208+k] = c[208+k] & m[15+k];
      return r;
   endfunction

   function automatic logic [256:0] rnd_cap();
      logic [256:0] r;
      for (int k = 0; k < 257; k += 32) r = {r[224:0], 32'($urandom)};
      return r;
   endfunction

   // one cycle of stimulus, then compare against the model
   task automatic op(input logic v, input logic [31:0] w, input logic [256:0] c,
                     input logic [63:0] m, input logic dl, input logic sl, input string req);
      logic rec, e_wr, e_exc;
      logic [7:0] e_cause;
      logic [4:0] e_idx, e_widx;
      logic [256:0] e_cap;
      @(negedge clk);
      insn_valid = v; insn_word = w; src_cap = c; mask_gpr = m;
      dst_locked = dl; src_locked = sl;
      #0.5;
      check(src_sel == w[15:11] && gpr_sel == w[10:6], "R2", "sel",
            {src_sel, gpr_sel}, {w[15:11], w[10:6]});
      rec = v && w[31:26] == 6'b010010 && w[25:21] == 5'b00100 && w[5:0] == 6'd0;
      e_cause = 8'h00; e_idx = 5'd0;
      if (rec) begin
         if (dl)          begin e_cause = 8'h18; e_idx = w[20:16]; end
         else if (sl)     begin e_cause = 8'h18; e_idx = w[15:11]; end
         else if (!c[256]) begin e_cause = 8'h02; e_idx = w[15:11]; end
         else if (c[192]) begin e_cause = 8'h03; e_idx = w[15:11]; end
      end
      e_exc = rec && e_cause != 8'h00;
      e_wr  = rec && !e_exc;
      e_cap = e_wr ? model_cap(c, m) : '0;
      e_widx = e_wr ? w[20:16] : 5'd0;
      @(posedge clk);
      #1;
      check(wr_en == e_wr && exc_valid == e_exc, req, "strobes",
            {wr_en, exc_valid}, {e_wr, e_exc});
      check(exc_cause == e_cause && exc_idx == e_idx, req, "cause/idx",
            {exc_cause, exc_idx}, {e_cause, e_idx});
      check(wr_idx == e_widx && wr_cap == e_cap, req, "wr_idx/wr_cap",
            wr_cap ^ {252'd0, wr_idx}, e_cap ^ {252'd0, e_widx});
      insn_valid = 1'b0;
   endtask

   logic [256:0] good;

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(!wr_en && !exc_valid && wr_cap == '0 && exc_cause == 8'd0 && wr_idx == 5'd0 && exc_idx == 5'd0,
            "R14", "reset", {wr_en, exc_valid, exc_cause}, '0);
      @(negedge clk) rst_n = 1'b1;

      // valid source: tagged, unsealed, all permissions set
      good = '1; good[192] = 1'b0;

      op(1, mk(5'd3, 5'd7, 5'd9), good, 64'h0000_0000_7FFF_FCFF, 0, 0, "R8");
      op(1, mk(5'd3, 5'd7, 5'd9), good, 64'h0000_0000_5555_4000, 0, 0, "R9");
      op(1, mk(5'd1, 5'd2, 5'd4), good, 64'h0000_0000_0000_2C00, 0, 0, "R9");
      op(1, mk(5'd30, 5'd31, 5'd0), good, 64'h0000_0000_0000_00A5, 0, 0, "R10");
      op(1, mk(5'd30, 5'd31, 5'd0), good, 64'd0, 0, 0, "R11");
      // R12: ignored mask bits set and clear must give the same result
      op(1, mk(5'd5, 5'd6, 5'd7), good, 64'h0000_0000_1234_5678 & 64'h7FFF_FCFF, 0, 0, "R12");
      op(1, mk(5'd5, 5'd6, 5'd7), good, 64'hFFFF_FFFF_9234_5778, 0, 0, "R12");
      // R1: near-miss words
      op(1, mk(5'd5, 5'd6, 5'd7) | 32'h1, good, '1, 0, 0, "R1");
      op(1, mk(5'd5, 5'd6, 5'd7) | 32'h20, good, '1, 0, 0, "R1");
      op(1, mk(5'd5, 5'd6, 5'd7) ^ 32'h0020_0000, good, '1, 0, 0, "R1");
      op(1, mk(5'd5, 5'd6, 5'd7) ^ 32'h8000_0000, good, '1, 0, 0, "R1");
      // R3: no strobe, recognised word present
      op(0, mk(5'd5, 5'd6, 5'd7), good, '1, 1, 1, "R3");
      op(0, mk(5'd5, 5'd6, 5'd7), good, '1, 0, 0, "R13");

      // priority sweep over the four fault conditions
      for (int f = 0; f < 16; f++) begin
         logic [256:0] c = good;
         string req;
         c[256] = !f[2];
         c[192] = f[3];
         if (f[0])      req = "R4";
         else if (f[1]) req = "R5";
         else if (f[2]) req = "R6";
         else if (f[3]) req = "R7";
         else           req = "R7";
         op(1, mk(5'd12, 5'd21, 5'd3), c, '1, f[0], f[1], req);
      end

      // random traffic
      for (int i = 0; i < 400; i++) begin
         logic [31:0] w = ($urandom % 4 != 0) ? mk(5'($urandom), 5'($urandom), 5'($urandom))
                                             : 32'($urandom);
         logic [256:0] c = rnd_cap();
         if ($urandom % 2 == 0) c[256] = 1'b1;
         if ($urandom % 2 == 0) c[192] = 1'b0;
         op(1'($urandom % 8 != 0), w, c, {32'($urandom), 32'($urandom)},
            1'($urandom % 6 == 0), 1'($urandom % 6 == 0), "R3/R8");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired act=%0d exp=%0d", n_chk, 0);
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end
endmodule